// File: doc/BRIEF.md
# Floating-Point NaN Propagation Selector

This block sits beside a floating-point arithmetic pipeline and decides whether an operation's result is set by a NaN input rather than by the arithmetic. It takes up to three operands, all single or all double precision, and an operand-count mode: one operand (square root, round to integral), two operands (add, subtract, multiply, divide, min/max), or three operands (fused multiply-add, where the first operand is the addend). If any active operand is a NaN, the block raises a NaN-result flag and outputs the NaN the result must carry.

The chosen NaN is found in two passes. Signalling NaNs are searched first, from the first operand to the third. Quiet NaNs are searched only if no signalling NaN is present, in the same order. With default-NaN mode off, the chosen NaN leaves with its quiet bit set and its sign and other payload bits unchanged. With default-NaN mode on, every NaN result becomes the format's single canonical value. The decision is combinational and registered once, so results appear one clock after `in_valid`.

Top module: `fp_nan_select`

## Requirements
- R1: A signalling NaN on any active operand is chosen over a quiet NaN on any active operand, including a quiet NaN on an earlier operand.
- R2: Among active operands of the same NaN class, the lowest-numbered operand wins (operand a before b before c).
- R3: With default-NaN mode off (`dflt_nan`=0), the result is the chosen operand with its top fraction bit (bit 22 single, bit 51 double) set to 1 and every other bit unchanged.
- R4: With default-NaN mode on, any NaN result is 0x7FC00000 in single format and 0x7FF8000000000000 in double format, whatever the input payload.
- R5: If no active operand is a NaN, `nan_out` is 0 and `res_out` is 0.
- R6: `op_mode` 2'b00 activates operand a only; 2'b01 activates a and b; 2'b10 and 2'b11 activate a, b and c. A NaN on an inactive operand has no effect.
- R7: With `fmt_dbl`=0 (single), only bits [31:0] of each operand are examined, and `res_out[63:32]` is zero. With `fmt_dbl`=1, all 64 bits are used, so a single-precision NaN pattern in the low half is not a NaN.
- R8: A value is a NaN only when its exponent field is all ones and its fraction is nonzero; a signalling NaN has the top fraction bit 0, a quiet NaN has it 1. Infinities (all-ones exponent, zero fraction) raise no flag.
- R9: `out_valid` equals `in_valid` delayed by one clock; `nan_out` and `res_out` belong to that sample. A synchronous reset (`rst`=1) clears `out_valid`, `nan_out` and `res_out` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision |
| op_mode | input | 2 | Active operand count: 00 one, 01 two, 1x three |
| dflt_nan | input | 1 | 1 = replace every NaN result with the default NaN |
| op_a | input | 64 | First operand (addend in three-operand mode) |
| op_b | input | 64 | Second operand |
| op_c | input | 64 | Third operand |
| out_valid | output | 1 | Registered result is valid |
| nan_out | output | 1 | The result is a NaN chosen from the inputs |
| res_out | output | 64 | The NaN result; zero when `nan_out` is 0 |

## Verification
The bench aims at the ordering corner: a quiet NaN on operand a with a signalling NaN on operand c, where a plain first-NaN-wins scan would return the quiet payload instead of the quietened signalling one, and two NaNs of one class, where a reversed scan would return the later payload. It drives infinities and single-precision NaN patterns hidden in the low half of a double operand, which a classifier that checks only the exponent, or the wrong field positions, would flag as NaNs. It places NaNs on operands outside the active count, which a design ignoring `op_mode` would propagate, and gives garbage in the upper half of single operands, which would leak into the zero-extended result or the classification. Default-NaN cases with nonzero payloads and negative signs catch a design that keeps payload or sign bits in that mode.

// File: rtl/fpns_pkg.sv
package fpns_pkg;

   localparam int NUM_OPS = 3;

   typedef enum logic [1:0] {
      MODE_ONE       = 2'b00,
      MODE_TWO       = 2'b01,
      MODE_THREE     = 2'b10,
      MODE_THREE_ALT = 2'b11
   } op_mode_e;

   // Operands that take part in the NaN search for a given mode.
   function automatic logic [NUM_OPS-1:0] active_mask(input logic [1:0] mode);
      logic [NUM_OPS-1:0] m;
      case (op_mode_e'(mode))
         MODE_ONE: m = NUM_OPS'(1);
         MODE_TWO: m = NUM_OPS'(3);
         default:  m = '1;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/fpns_class.sv
// Classifies one operand as signalling or quiet NaN for one format.
module fpns_class #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int MAG_W = EXP_W + FRAC_W
) (
   input  logic [MAG_W-1:0] mag,
   input  logic             en,
   output logic             is_snan,
   output logic             is_qnan
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_full;
   logic              qbit;
   logic              low_nz;

   assign exp_f    = mag[MAG_W-1:FRAC_W];
   assign frac_f   = mag[FRAC_W-1:0];
   assign exp_full = &exp_f;
   assign qbit     = frac_f[FRAC_W-1];
   assign low_nz   = |frac_f[FRAC_W-2:0];

   assign is_qnan = en & exp_full & qbit;
   assign is_snan = en & exp_full & ~qbit & low_nz;

endmodule

// File: rtl/fpns_pick.sv
// Two-pass priority: signalling NaNs first, then quiet; lowest index wins.
module fpns_pick #(
   parameter int N = 3,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     snan,
   input  logic [N-1:0]     qnan,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      hit = (|snan) | (|qnan);
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (qnan[i]) idx = IDX_W'(i);
      end
      for (int i = N - 1; i >= 0; i--) begin
         if (snan[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/fpns_form.sv
// Builds the NaN result for one format: quietened input or canonical value.
module fpns_form #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int OUT_W  = 64,
   localparam int FMT_W = 1 + EXP_W + FRAC_W
) (
   input  logic [FMT_W-1:0] op,
   input  logic             dn,
   output logic [OUT_W-1:0] res
);

   localparam logic [FMT_W-1:0] QBIT = FMT_W'(1) << (FRAC_W - 1);
   localparam logic [FMT_W-1:0] CANON =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [FMT_W-1:0] pick;

   assign pick = dn ? CANON : (op | QBIT);

   generate
      if (OUT_W == FMT_W) begin : g_same
         assign res = pick;
      end else begin : g_ext
         assign res = {{(OUT_W-FMT_W){1'b0}}, pick};
      end
   endgenerate

endmodule

// File: rtl/fp_nan_select.sv
module fp_nan_select #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   input  logic                          fmt_dbl,
   input  logic [1:0]                    op_mode,
   input  logic                          dflt_nan,
   input  logic [DP_EXP_W+DP_FRAC_W:0]   op_a,
   input  logic [DP_EXP_W+DP_FRAC_W:0]   op_b,
   input  logic [DP_EXP_W+DP_FRAC_W:0]   op_c,
   output logic                          out_valid,
   output logic                          nan_out,
   output logic [DP_EXP_W+DP_FRAC_W:0]   res_out
);

   import fpns_pkg::*;

   localparam int DATA_W = 1 + DP_EXP_W + DP_FRAC_W;
   localparam int SP_W   = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int SP_MAG = SP_EXP_W + SP_FRAC_W;
   localparam int DP_MAG = DP_EXP_W + DP_FRAC_W;
   localparam int IDX_W  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;

   generate
      if (SP_W > DATA_W) begin : g_bad_width
         $error("single format must fit inside the double operand width");
      end
      if (SP_FRAC_W < 2 || DP_FRAC_W < 2) begin : g_bad_frac
         $error("fraction fields need at least two bits");
      end
      if (SP_EXP_W < 2 || DP_EXP_W < 2) begin : g_bad_exp
         $error("exponent fields need at least two bits");
      end
   endgenerate

   logic [DATA_W-1:0]  ops [NUM_OPS];
   logic [NUM_OPS-1:0] act;
   logic [NUM_OPS-1:0] snan_v;
   logic [NUM_OPS-1:0] qnan_v;
   logic               hit;
   logic [IDX_W-1:0]   idx;
   logic [DATA_W-1:0]  sel_op;
   logic [DATA_W-1:0]  res_sp;
   logic [DATA_W-1:0]  res_dp;
   logic [DATA_W-1:0]  res_nxt;

   assign ops[0] = op_a;
   assign ops[1] = op_b;
   assign ops[2] = op_c;
   assign act    = active_mask(op_mode);

   // One classifier per operand and per format; the format input picks.
   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         logic sp_s, sp_q, dp_s, dp_q;

         fpns_class #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_cls_sp (
            .mag     (ops[g][SP_MAG-1:0]),
            .en      (act[g] & ~fmt_dbl),
            .is_snan (sp_s),
            .is_qnan (sp_q)
         );

         fpns_class #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_cls_dp (
            .mag     (ops[g][DP_MAG-1:0]),
            .en      (act[g] & fmt_dbl),
            .is_snan (dp_s),
            .is_qnan (dp_q)
         );

         assign snan_v[g] = sp_s | dp_s;
         assign qnan_v[g] = sp_q | dp_q;
      end
   endgenerate

   fpns_pick #(.N(NUM_OPS)) u_pick (
      .snan (snan_v),
      .qnan (qnan_v),
      .hit  (hit),
      .idx  (idx)
   );

   assign sel_op = ops[idx];

   fpns_form #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .OUT_W(DATA_W)) u_form_sp (
      .op  (sel_op[SP_W-1:0]),
      .dn  (dflt_nan),
      .res (res_sp)
   );

   fpns_form #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .OUT_W(DATA_W)) u_form_dp (
      .op  (sel_op),
      .dn  (dflt_nan),
      .res (res_dp)
   );

   assign res_nxt = !hit ? '0 : (fmt_dbl ? res_dp : res_sp);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         nan_out   <= 1'b0;
         res_out   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            nan_out <= hit;
            res_out <= res_nxt;
         end
      end
   end

endmodule

// File: rtl/fpns_chk.sv
module fpns_chk (
   input logic        clk,
   input logic        rst,
   input logic        in_valid,
   input logic        fmt_dbl,
   input logic [1:0]  op_mode,
   input logic        dflt_nan,
   input logic [63:0] op_a,
   input logic [63:0] op_b,
   input logic [63:0] op_c,
   input logic        out_valid,
   input logic        nan_out,
   input logic [63:0] res_out
);

   // Independent view of which active inputs are NaNs.
   function automatic logic is_nan(input logic [63:0] v, input logic dbl);
      if (dbl) return (&v[62:52]) && (|v[51:0]);
      return (&v[30:23]) && (|v[22:0]);
   endfunction

   logic any_nan_in;
   always_comb begin
      any_nan_in = is_nan(op_a, fmt_dbl);
      if (op_mode != 2'b00) any_nan_in = any_nan_in | is_nan(op_b, fmt_dbl);
      if (op_mode[1])       any_nan_in = any_nan_in | is_nan(op_c, fmt_dbl);
   end

   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (!out_valid && !nan_out && res_out == 64'h0));

   assert_no_nan_in_R5_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !any_nan_in) |=> (!nan_out && res_out == 64'h0));

   assert_nan_in_flag_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && any_nan_in) |=> nan_out);

   assert_default_dp_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dflt_nan && fmt_dbl && any_nan_in) |=>
         (res_out == 64'h7FF8_0000_0000_0000));

   assert_default_sp_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dflt_nan && !fmt_dbl && any_nan_in) |=>
         (res_out == 64'h0000_0000_7FC0_0000));

   assert_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !fmt_dbl) |=> (res_out[63:32] == 32'h0));

   assert_quiet_dp_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && fmt_dbl && any_nan_in) |=> (res_out[62:51] == 12'hFFF));

   assert_quiet_sp_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !fmt_dbl && any_nan_in) |=> (res_out[30:22] == 9'h1FF));

endmodule

bind fp_nan_select fpns_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .fmt_dbl   (fmt_dbl),
   .op_mode   (op_mode),
   .dflt_nan  (dflt_nan),
   .op_a      (op_a),
   .op_b      (op_b),
   .op_c      (op_c),
   .out_valid (out_valid),
   .nan_out   (nan_out),
   .res_out   (res_out)
);

// File: tb/fp_nan_select_tb.sv
`timescale 1ns/1ps
module fp_nan_select_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        fmt_dbl = 1'b0;
   logic [1:0]  op_mode = 2'b01;
   logic        dflt_nan = 1'b0;
   logic [63:0] op_a = '0, op_b = '0, op_c = '0;
   logic        out_valid, nan_out;
   logic [63:0] res_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fp_nan_select u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
      .op_mode(op_mode), .dflt_nan(dflt_nan), .op_a(op_a), .op_b(op_b),
      .op_c(op_c), .out_valid(out_valid), .nan_out(nan_out), .res_out(res_out)
   );

   localparam logic [63:0] S1 = 64'h0000_0000_3F80_0000;
   localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000;
   localparam int NV = 19;

   // {fmt_dbl, op_mode, dflt_nan, op_a, op_b, op_c, exp_flag, exp_res}
   localparam logic [260:0] VECS [NV] = '{
      {1'b0, 2'b01, 1'b0, S1, S1, S1, 1'b0, 64'h0},
      {1'b0, 2'b10, 1'b0, 64'h7FC0_1111, S1, 64'h7F80_5678, 1'b1, 64'h7FC0_5678},
      {1'b0, 2'b10, 1'b0, S1, 64'hFFC0_2222, 64'h7FC0_3333, 1'b1, 64'hFFC0_2222},
      {1'b0, 2'b10, 1'b0, 64'h7F80_0001, 64'h7F80_0002, S1, 1'b1, 64'h7FC0_0001},
      {1'b0, 2'b01, 1'b1, S1, 64'h7F80_5678, S1, 1'b1, 64'h7FC0_0000},
      {1'b1, 2'b10, 1'b0, D1, 64'h7FF8_0000_0000_ABCD, 64'hFFF0_0000_0000_0042,
       1'b1, 64'hFFF8_0000_0000_0042},
      {1'b1, 2'b10, 1'b1, 64'h7FF8_0000_0000_ABCD, D1, D1, 1'b1, 64'h7FF8_0000_0000_0000},
      {1'b0, 2'b00, 1'b0, S1, 64'h7F80_5678, 64'h7F80_5678, 1'b0, 64'h0},
      {1'b0, 2'b01, 1'b0, S1, S1, 64'h7F80_5678, 1'b0, 64'h0},
      {1'b0, 2'b00, 1'b0, 64'hFF80_0001, S1, S1, 1'b1, 64'hFFC0_0001},
      {1'b0, 2'b01, 1'b0, 64'hFFF0_0000_3F80_0000, S1, S1, 1'b0, 64'h0},
      {1'b0, 2'b01, 1'b0, 64'hDEAD_BEEF_7F80_1000, S1, S1, 1'b1, 64'h7FC0_1000},
      {1'b0, 2'b01, 1'b0, 64'h7F80_0000, 64'hFF80_0000, S1, 1'b0, 64'h0},
      {1'b1, 2'b01, 1'b0, 64'h7FF0_0000_0000_0000, D1, D1, 1'b0, 64'h0},
      {1'b1, 2'b01, 1'b0, 64'h7FF0_0000_0000_0001, D1, D1, 1'b1, 64'h7FF8_0000_0000_0001},
      {1'b1, 2'b01, 1'b0, D1, 64'h0000_0000_7FC0_0000, D1, 1'b0, 64'h0},
      {1'b1, 2'b11, 1'b0, D1, D1, 64'h7FF8_0000_0000_ABCD, 1'b1, 64'h7FF8_0000_0000_ABCD},
      {1'b0, 2'b10, 1'b1, 64'h7FC0_1111, 64'h7F80_5678, S1, 1'b1, 64'h7FC0_0000},
      {1'b0, 2'b01, 1'b0, 64'h7FC0_9999, 64'h7F80_5678, S1, 1'b1, 64'h7FC0_5678}
   };

   localparam string TAGS [NV] = '{
      "R5", "R1", "R2", "R2", "R4", "R1", "R4", "R6", "R6", "R3",
      "R7", "R7", "R8", "R8", "R8", "R7", "R6", "R4", "R1"
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200_000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // Reset state, with a NaN presented while reset is held (R9).
      in_valid = 1'b1;
      op_a = 64'h7F80_0001;
      repeat (3) @(negedge clk);
      chk("R9 reset out_valid", {63'h0, out_valid}, 64'h0);
      chk("R9 reset nan_out", {63'h0, nan_out}, 64'h0);
      chk("R9 reset res_out", res_out, 64'h0);
      rst = 1'b0;

      // Table walk, back-to-back valid samples.
      for (int i = 0; i < NV; i++) begin
         logic [260:0] v;
         v = VECS[i];
         fmt_dbl  = v[260];
         op_mode  = v[259:258];
         dflt_nan = v[257];
         op_a     = v[256:193];
         op_b     = v[192:129];
         op_c     = v[128:65];
         in_valid = 1'b1;
         @(negedge clk);
         chk({TAGS[i], " R9 out_valid"}, {63'h0, out_valid}, 64'h1);
         chk({TAGS[i], " flag"}, {63'h0, nan_out}, {63'h0, v[64]});
         chk({TAGS[i], " result"}, res_out, v[63:0]);
      end

      // Idle cycle drops out_valid one clock later (R9).
      in_valid = 1'b0;
      fmt_dbl = 1'b0; op_mode = 2'b01; dflt_nan = 1'b0;
      op_a = 64'h7F80_0003; op_b = S1; op_c = S1;
      @(negedge clk);
      chk("R9 idle out_valid", {63'h0, out_valid}, 64'h0);

      // Valid sample then reset on the following edge clears everything (R9).
      in_valid = 1'b1;
      @(negedge clk);
      chk("R3 pre-reset result", res_out, 64'h7FC0_0003);
      rst = 1'b1;
      @(negedge clk);
      chk("R9 mid reset out_valid", {63'h0, out_valid}, 64'h0);
      chk("R9 mid reset nan_out", {63'h0, nan_out}, 64'h0);
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      finish_run();
   end

endmodule